// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor placed on the command bus between a memory controller and a four-bank SDRAM. Every clock it takes one decoded command, the bank it addresses and the CAS-latency setting. It keeps per-bank and cross-bank down-counters, and it decides whether the command arrived before the minimum spacing, in clock cycles, that the device needs after earlier commands. A violating command raises a one-cycle pulse one clock after it was presented. The pulse carries a rule code and the bank of the offending command. The monitor still folds that command into its timing state, just as the device would see it.

The minimum spacings are parameters. Open-row timing, row cycle, precharge recovery, write recovery, bank-to-bank activation, mode-register settling and the self-refresh exit window each have one. The burst length and the early-precharge offsets for the two CAS latencies are parameters as well. The composite constraints are derived from them: auto-precharge recovery and the read-to-precharge distance. The monitor has no data path and does not count refresh intervals.

Top module: `sdt_timing_checker`

## Requirements
- R1: After reset every counter is clear and every bank is idle, so the first command of any kind raises no violation, and violation, ruleCode and violBank read 0.
- R2: NOP (cmd 0), DESL (cmd 1) and the unused codes 12 to 15 never raise a violation. The outputs are registered: the result for a command shows one clock after that command is presented. With no violation, ruleCode and violBank are 0.
- R3: A column command (RD 3, RDA 4, WR 5, WRA 6) to a bank sooner than ACT2COL (default 2) clocks after an ACT (cmd 2) to that bank violates with code 7.
- R4: An ACT to a bank sooner than ACT2ACT (default 8) clocks after the previous ACT to the same bank violates with code 4.
- R5: A PRE (cmd 7) to a bank sooner than ACT2PRE (default 6) clocks after an ACT to that bank violates with code 8.
- R6: An ACT to a bank sooner than PRE2ACT (default 2) clocks after a PRE to that bank violates with code 5.
- R7: Write data is taken from the WR cycle on, so the last beat is BURST_LEN-1 clocks after WR or WRA. A PRE to that bank sooner than BURST_LEN-1+WR_RECOV clocks after the write violates with code 9.
- R8: With CAS latency CL (casLat3=0 means 2, casLat3=1 means 3), the last read beat is at CL+BURST_LEN-1. PRE may come EARLY_CL2 (1) or EARLY_CL3 (2) clocks before that beat. A PRE to that bank sooner than CL+BURST_LEN-1-EARLY clocks after RD or RDA violates with code 10.
- R9: An ACT to a bank other than the one of the last ACT, sooner than BANK2BANK (default 2) clocks after that ACT, violates with code 3.
- R10: An ACT sooner than BURST_LEN-1+WR_RECOV+PRE2ACT clocks after a WRA to that bank violates with code 6. The same holds for an ACT sooner than CL+BURST_LEN-1-EARLY+PRE2ACT clocks after an RDA.
- R11: An ACT to any bank sooner than MODE2ACT (default 2) clocks after MRS (cmd 8) violates with code 2.
- R12: Within EXIT_WIN (default 1) clocks after self-refresh exit (cmd 10), any command other than NOP or DESL violates with code 1. SRE (9), SRX (10) and PDX (11) count as such commands.
- R13: When several rules fail at once, the lowest code is reported. violBank is the bank of the offending command. A violating command still updates the timing state as if it were legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 4 | Decoded command code presented this cycle |
| bank | input | 2 | Bank addressed by the command |
| casLat3 | input | 1 | CAS latency select: 0 selects 2, 1 selects 3 |
| violation | output | 1 | One-cycle pulse for a too-early command |
| ruleCode | output | 4 | Code of the violated rule, 0 when none |
| violBank | output | 2 | Bank of the offending command, 0 when none |

## Verification
The hardest situations to reach are composite windows that only open after a chain of legal commands. One example is a WRA or RDA whose recovery outlasts the row cycle, so that only the auto-precharge rule fails. Another is a self-refresh exit landing next to an open row cycle, where the priority decides the code. Directed sequences build each chain one clock at a time, with the bench in a longer burst configuration. Each one probes one clock before and exactly at the boundary.

Weighted random traffic with many NOPs then spreads commands over short distances across all four banks and both CAS latencies. It is compared every cycle against a ready-time model.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_DESL = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_RDA  = 4'd4,
    CMD_WR   = 4'd5,
    CMD_WRA  = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_MRS  = 4'd8,
    CMD_SRE  = 4'd9,
    CMD_SRX  = 4'd10,
    CMD_PDX  = 4'd11
  } cmd_e;

  // Lower value wins when several rules fail together
  typedef enum logic [3:0] {
    RULE_NONE     = 4'd0,
    RULE_EXITWIN  = 4'd1,
    RULE_MODE2ACT = 4'd2,
    RULE_BANK2BANK = 4'd3,
    RULE_ACT2ACT  = 4'd4,
    RULE_PRE2ACT  = 4'd5,
    RULE_AUTO2ACT = 4'd6,
    RULE_ACT2COL  = 4'd7,
    RULE_ACT2PRE  = 4'd8,
    RULE_WR2PRE   = 4'd9,
    RULE_RD2PRE   = 4'd10
  } rule_e;

  typedef struct packed {
    logic act;
    logic col;
    logic rd;
    logic wr;
    logic autoPre;
    logic pre;
    logic mode;
    logic srExit;
    logic valid;
  } strobe_t;

  typedef struct packed {
    logic act2col;
    logic act2act;
    logic act2pre;
    logic pre2act;
    logic auto2act;
    logic wr2pre;
    logic rd2pre;
  } busy_t;

endpackage

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
(
  input  logic [3:0] cmdIn,
  output strobe_t    stb
);

  always_comb begin
    stb = '0;
    case (cmdIn)
      CMD_ACT: begin
        stb.act   = 1'b1;
        stb.valid = 1'b1;
      end
      CMD_RD: begin
        stb.rd    = 1'b1;
        stb.col   = 1'b1;
        stb.valid = 1'b1;
      end
      CMD_RDA: begin
        stb.rd      = 1'b1;
        stb.col     = 1'b1;
        stb.autoPre = 1'b1;
        stb.valid   = 1'b1;
      end
      CMD_WR: begin
        stb.wr    = 1'b1;
        stb.col   = 1'b1;
        stb.valid = 1'b1;
      end
      CMD_WRA: begin
        stb.wr      = 1'b1;
        stb.col     = 1'b1;
        stb.autoPre = 1'b1;
        stb.valid   = 1'b1;
      end
      CMD_PRE: begin
        stb.pre   = 1'b1;
        stb.valid = 1'b1;
      end
      CMD_MRS: begin
        stb.mode  = 1'b1;
        stb.valid = 1'b1;
      end
      CMD_SRE: stb.valid = 1'b1;
      CMD_SRX: begin
        stb.srExit = 1'b1;
        stb.valid  = 1'b1;
      end
      CMD_PDX: stb.valid = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sdt_bank_timer.sv
module sdt_bank_timer
  import sdt_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int ACT2COL   = 2,
  parameter int ACT2ACT   = 8,
  parameter int ACT2PRE   = 6,
  parameter int PRE2ACT   = 2,
  parameter int WRPRE_LD  = 1,
  parameter int AUTOWR_LD = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             isAct,
  input  logic             isRd,
  input  logic             isWr,
  input  logic             isAuto,
  input  logic             isPre,
  input  logic [CNT_W-1:0] rdPreLd,
  input  logic [CNT_W-1:0] autoRdLd,
  output busy_t            busy
);

  localparam int NCNT = 7;

  logic [CNT_W-1:0] cnt   [NCNT];
  logic [CNT_W-1:0] ldVal [NCNT];
  logic [NCNT-1:0]  ld;

  always_comb begin
    ld[0] = sel & isAct;           ldVal[0] = CNT_W'(ACT2COL - 1);
    ld[1] = sel & isAct;           ldVal[1] = CNT_W'(ACT2ACT - 1);
    ld[2] = sel & isAct;           ldVal[2] = CNT_W'(ACT2PRE - 1);
    ld[3] = sel & isPre;           ldVal[3] = CNT_W'(PRE2ACT - 1);
    ld[4] = sel & isAuto;          ldVal[4] = isWr ? CNT_W'(AUTOWR_LD) : autoRdLd;
    ld[5] = sel & isWr;            ldVal[5] = CNT_W'(WRPRE_LD);
    ld[6] = sel & isRd;            ldVal[6] = rdPreLd;
  end

  for (genvar g = 0; g < NCNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cnt[g] <= '0;
      else if (ld[g])          cnt[g] <= ldVal[g];
      else if (cnt[g] != '0)   cnt[g] <= cnt[g] - 1'b1;
    end
  end

  assign busy.act2col  = (cnt[0] != '0);
  assign busy.act2act  = (cnt[1] != '0);
  assign busy.act2pre  = (cnt[2] != '0);
  assign busy.pre2act  = (cnt[3] != '0);
  assign busy.auto2act = (cnt[4] != '0);
  assign busy.wr2pre   = (cnt[5] != '0);
  assign busy.rd2pre   = (cnt[6] != '0);

endmodule

// File: rtl/sdt_datapath.sv
module sdt_datapath
  import sdt_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 5,
  parameter int ACT2COL   = 2,
  parameter int ACT2ACT   = 8,
  parameter int ACT2PRE   = 6,
  parameter int PRE2ACT   = 2,
  parameter int WR_RECOV  = 2,
  parameter int BANK2BANK = 2,
  parameter int MODE2ACT  = 2,
  parameter int EXIT_WIN  = 1,
  parameter int BURST_LEN = 1,
  parameter int EARLY_CL2 = 1,
  parameter int EARLY_CL3 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              cl3,
  output logic              violation,
  output logic [3:0]        ruleCode,
  output logic [BANK_W-1:0] violBank
);

  // Distances counted from the column command; loads are distance minus one
  localparam int WRPRE_LD  = BURST_LEN - 1 + WR_RECOV - 1;
  localparam int AUTOWR_LD = BURST_LEN - 1 + WR_RECOV + PRE2ACT - 1;
  localparam int RDPRE2    = 2 + BURST_LEN - 1 - EARLY_CL2;
  localparam int RDPRE3    = 3 + BURST_LEN - 1 - EARLY_CL3;

  logic [CNT_W-1:0] rdPreLd, autoRdLd;
  assign rdPreLd  = cl3 ? CNT_W'(RDPRE3 - 1) : CNT_W'(RDPRE2 - 1);
  assign autoRdLd = cl3 ? CNT_W'(RDPRE3 + PRE2ACT - 1) : CNT_W'(RDPRE2 + PRE2ACT - 1);

  busy_t bankBusy [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    sdt_bank_timer #(
      .CNT_W(CNT_W), .ACT2COL(ACT2COL), .ACT2ACT(ACT2ACT), .ACT2PRE(ACT2PRE),
      .PRE2ACT(PRE2ACT), .WRPRE_LD(WRPRE_LD), .AUTOWR_LD(AUTOWR_LD)
    ) uBank (
      .clk(clk), .rstN(rstN), .sel(bankIn == BANK_W'(b)),
      .isAct(stb.act), .isRd(stb.rd), .isWr(stb.wr), .isAuto(stb.autoPre),
      .isPre(stb.pre), .rdPreLd(rdPreLd), .autoRdLd(autoRdLd),
      .busy(bankBusy[b])
    );
  end

  busy_t cur;
  assign cur = bankBusy[bankIn];

  logic [CNT_W-1:0]  b2bCnt, modeCnt, exitCnt;
  logic [BANK_W-1:0] lastActBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      b2bCnt      <= '0;
      modeCnt     <= '0;
      exitCnt     <= '0;
      lastActBank <= '0;
    end else begin
      if (stb.act) begin
        b2bCnt      <= CNT_W'(BANK2BANK - 1);
        lastActBank <= bankIn;
      end else if (b2bCnt != '0) b2bCnt <= b2bCnt - 1'b1;
      if (stb.mode)               modeCnt <= CNT_W'(MODE2ACT - 1);
      else if (modeCnt != '0)     modeCnt <= modeCnt - 1'b1;
      if (stb.srExit)             exitCnt <= CNT_W'(EXIT_WIN);
      else if (exitCnt != '0)     exitCnt <= exitCnt - 1'b1;
    end
  end

  rule_e nextCode;

  always_comb begin
    nextCode = RULE_NONE;
    if (stb.valid && exitCnt != '0)                          nextCode = RULE_EXITWIN;
    else if (stb.act && modeCnt != '0)                       nextCode = RULE_MODE2ACT;
    else if (stb.act && b2bCnt != '0 && bankIn != lastActBank) nextCode = RULE_BANK2BANK;
    else if (stb.act && cur.act2act)                         nextCode = RULE_ACT2ACT;
    else if (stb.act && cur.pre2act)                         nextCode = RULE_PRE2ACT;
    else if (stb.act && cur.auto2act)                        nextCode = RULE_AUTO2ACT;
    else if (stb.col && cur.act2col)                         nextCode = RULE_ACT2COL;
    else if (stb.pre && cur.act2pre)                         nextCode = RULE_ACT2PRE;
    else if (stb.pre && cur.wr2pre)                          nextCode = RULE_WR2PRE;
    else if (stb.pre && cur.rd2pre)                          nextCode = RULE_RD2PRE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      ruleCode  <= '0;
      violBank  <= '0;
    end else begin
      violation <= (nextCode != RULE_NONE);
      ruleCode  <= nextCode;
      violBank  <= (nextCode != RULE_NONE) ? bankIn : '0;
    end
  end

endmodule

// File: rtl/sdt_timing_checker.sv
module sdt_timing_checker
  import sdt_pkg::*;
#(
  parameter int BANKS     = 4,
  parameter int ACT2COL   = 2,
  parameter int ACT2ACT   = 8,
  parameter int ACT2PRE   = 6,
  parameter int PRE2ACT   = 2,
  parameter int WR_RECOV  = 2,
  parameter int BANK2BANK = 2,
  parameter int MODE2ACT  = 2,
  parameter int EXIT_WIN  = 1,
  parameter int BURST_LEN = 1,
  parameter int EARLY_CL2 = 1,
  parameter int EARLY_CL3 = 2,
  localparam int BANK_W   = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic              casLat3,
  output logic              violation,
  output logic [3:0]        ruleCode,
  output logic [BANK_W-1:0] violBank
);

  localparam int SPAN  = ACT2COL + ACT2ACT + ACT2PRE + PRE2ACT + WR_RECOV + BANK2BANK
                       + MODE2ACT + EXIT_WIN + BURST_LEN + 4;
  localparam int CNT_W = $clog2(SPAN + 1);

  strobe_t stb;

  sdt_ctrl uCtrl (
    .cmdIn(cmd),
    .stb(stb)
  );

  sdt_datapath #(
    .BANKS(BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .ACT2COL(ACT2COL), .ACT2ACT(ACT2ACT), .ACT2PRE(ACT2PRE), .PRE2ACT(PRE2ACT),
    .WR_RECOV(WR_RECOV), .BANK2BANK(BANK2BANK), .MODE2ACT(MODE2ACT),
    .EXIT_WIN(EXIT_WIN), .BURST_LEN(BURST_LEN),
    .EARLY_CL2(EARLY_CL2), .EARLY_CL3(EARLY_CL3)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .bankIn(bank), .cl3(casLat3),
    .violation(violation), .ruleCode(ruleCode), .violBank(violBank)
  );

endmodule

// File: rtl/sdt_checker.sv
module sdt_checker
  import sdt_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        cmd,
  input logic [BANK_W-1:0] bank,
  input logic              violation,
  input logic [3:0]        ruleCode,
  input logic [BANK_W-1:0] violBank
);

  logic isValid, isCol;
  assign isValid = (cmd >= 4'd2) && (cmd <= 4'd11);
  assign isCol   = (cmd >= 4'd3) && (cmd <= 4'd6);

  AST_QUIET_ON_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP || cmd == CMD_DESL) |=> !violation); // R2

  AST_IDLE_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    !violation |-> (ruleCode == 4'd0 && violBank == '0)); // R13

  AST_EXIT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == CMD_SRX && isValid) |=> (violation && ruleCode == 4'd1)); // R12

  AST_ACT_TO_COL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == CMD_ACT && isCol && bank == $past(bank)) |=> violation); // R3

  AST_ACT_SAME_BANK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == CMD_ACT && cmd == CMD_ACT && bank == $past(bank)) |=> violation); // R4

  AST_ACT_OTHER_BANK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == CMD_ACT && cmd == CMD_ACT && bank != $past(bank)) |=> violation); // R9

  AST_MODE_TO_ACT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmd) == CMD_MRS && cmd == CMD_ACT) |=> violation); // R11

endmodule

bind sdt_timing_checker sdt_checker #(.BANK_W(BANK_W)) uChk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .bank(bank),
  .violation(violation), .ruleCode(ruleCode), .violBank(violBank)
);

// File: tb/tb_sdt_timing_checker.sv
`timescale 1ns/1ps
module tb_sdt_timing_checker;

  localparam int NOP = 0, DESL = 1, ACT = 2, RD = 3, RDA = 4, WR = 5, WRA = 6,
                 PRE = 7, MRS = 8, SRE = 9, SRX = 10, PDX = 11;
  localparam int T_A2C = 2, T_A2A = 8, T_A2P = 6, T_P2A = 2, T_WR = 2,
                 T_B2B = 2, T_MODE = 2, T_EXIT = 1, BL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [1:0] bank = 2'd0;
  logic casLat3 = 1'b0;
  logic violation;
  logic [3:0] ruleCode;
  logic [1:0] violBank;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sdt_timing_checker #(.BURST_LEN(BL)) dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bank(bank), .casLat3(casLat3),
    .violation(violation), .ruleCode(ruleCode), .violBank(violBank)
  );

  // Ready-time model: a command is early when now is below the ready time
  int now, rdyExit, rdyMode, rdyB2b, b2bBank;
  int rA2C[4], rA2A[4], rA2P[4], rP2A[4], rAuto[4], rW2P[4], rR2P[4];

  task automatic modelReset();
    now = 0; rdyExit = 0; rdyMode = 0; rdyB2b = 0; b2bBank = 0;
    for (int i = 0; i < 4; i++) begin
      rA2C[i] = 0; rA2A[i] = 0; rA2P[i] = 0; rP2A[i] = 0;
      rAuto[i] = 0; rW2P[i] = 0; rR2P[i] = 0;
    end
  endtask

  task automatic modelStep(input int c, input int b, input bit cl3, output int code);
    bit isAct, isCol, isPre, isValid;
    int cl, ep;
    isAct = (c == ACT);
    isCol = (c >= RD && c <= WRA);
    isPre = (c == PRE);
    isValid = (c >= ACT && c <= PDX);
    code = 0;
    if (isValid && now < rdyExit) code = 1;
    else if (isAct && now < rdyMode) code = 2;
    else if (isAct && now < rdyB2b && b != b2bBank) code = 3;
    else if (isAct && now < rA2A[b]) code = 4;
    else if (isAct && now < rP2A[b]) code = 5;
    else if (isAct && now < rAuto[b]) code = 6;
    else if (isCol && now < rA2C[b]) code = 7;
    else if (isPre && now < rA2P[b]) code = 8;
    else if (isPre && now < rW2P[b]) code = 9;
    else if (isPre && now < rR2P[b]) code = 10;
    if (isAct) begin
      rA2C[b] = now + T_A2C; rA2A[b] = now + T_A2A; rA2P[b] = now + T_A2P;
      rdyB2b = now + T_B2B; b2bBank = b;
    end
    if (isPre) rP2A[b] = now + T_P2A;
    if (c == WR || c == WRA) rW2P[b] = now + BL - 1 + T_WR;
    if (c == WRA) rAuto[b] = now + BL - 1 + T_WR + T_P2A;
    if (c == RD || c == RDA) begin
      cl = cl3 ? 3 : 2;
      ep = cl3 ? 2 : 1;
      rR2P[b] = now + cl + BL - 1 - ep;
      if (c == RDA) rAuto[b] = rR2P[b] + T_P2A;
    end
    if (c == MRS) rdyMode = now + T_MODE;
    if (c == SRX) rdyExit = now + 1 + T_EXIT;
    now++;
  endtask

  task automatic chk(input string tag, input int ecode, input int eb);
    bit ev;
    ev = (ecode != 0);
    checks++;
    if (violation !== ev || ruleCode !== 4'(ecode) || violBank !== (ev ? 2'(eb) : 2'd0)) begin
      errors++;
      $display("FAIL %s: got v=%0d code=%0d bank=%0d, expected v=%0d code=%0d bank=%0d",
               tag, violation, ruleCode, violBank, ev, ecode, ev ? eb : 0);
    end
  endtask

  task automatic step(input int c, input int b, input bit cl3, output int mcode);
    cmd = 4'(c); bank = 2'(b); casLat3 = cl3;
    modelStep(c, b, cl3, mcode);
    @(negedge clk);
  endtask

  task automatic dir(input int c, input int b, input bit cl3, input int ecode, input string tag);
    int m;
    step(c, b, cl3, m);
    chk(tag, ecode, b);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) dir(NOP, 0, 1'b0, 0, "R2 idle");
  endtask

  task automatic doReset();
    rstN = 1'b0; cmd = 4'd0; bank = 2'd0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m, r, c;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    doReset();
    chk("R1 reset outputs", 0, 0);
    dir(ACT, 0, 0, 0, "R1 first ACT");
    dir(RD, 0, 0, 7, "R3 early column");
    dir(RD, 0, 0, 0, "R3 boundary");
    dir(NOP, 2, 0, 0, "R2 NOP");
    dir(DESL, 3, 0, 0, "R2 DESL");
    dir(13, 1, 0, 0, "R2 unused code");

    doReset();
    dir(ACT, 1, 0, 0, "R5 setup");
    nops(4);
    dir(PRE, 1, 0, 8, "R5 early precharge");
    dir(PRE, 1, 0, 0, "R5 boundary");
    nops(1);
    dir(ACT, 1, 0, 0, "R4 R6 boundary");
    dir(ACT, 1, 0, 4, "R4 early same bank");

    doReset();
    dir(ACT, 2, 0, 0, "R6 setup");
    nops(6);
    dir(PRE, 2, 0, 0, "R6 precharge");
    dir(ACT, 2, 0, 5, "R6 early activate");

    doReset();
    dir(ACT, 3, 0, 0, "R7 setup");
    nops(1);
    dir(WR, 3, 0, 0, "R7 write");
    nops(3);
    dir(PRE, 3, 0, 9, "R7 early precharge");
    dir(PRE, 3, 0, 0, "R7 boundary");

    for (int k = 0; k < 2; k++) begin
      doReset();
      dir(ACT, 0, k[0], 0, "R8 setup");
      nops(3);
      dir(RD, 0, k[0], 0, "R8 read");
      nops(2);
      dir(PRE, 0, k[0], 10, "R8 early precharge");
      dir(PRE, 0, k[0], 0, "R8 boundary");
    end

    doReset();
    dir(ACT, 0, 0, 0, "R9 setup");
    dir(ACT, 1, 0, 3, "R9 early other bank");
    dir(ACT, 2, 0, 3, "R13 violating command updates state");
    nops(1);
    dir(ACT, 3, 0, 0, "R9 boundary");

    doReset();
    dir(ACT, 1, 0, 0, "R10 setup");
    nops(1);
    dir(WRA, 1, 0, 0, "R10 write auto");
    nops(5);
    dir(ACT, 1, 0, 6, "R10 early after write auto");

    doReset();
    dir(ACT, 1, 0, 0, "R10 setup");
    nops(1);
    dir(WRA, 1, 0, 0, "R10 write auto");
    nops(6);
    dir(ACT, 1, 0, 0, "R10 write auto boundary");

    doReset();
    dir(ACT, 1, 1, 0, "R10 setup");
    nops(2);
    dir(RDA, 1, 1, 0, "R10 read auto");
    nops(4);
    dir(ACT, 1, 1, 6, "R10 early after read auto");

    doReset();
    dir(ACT, 1, 0, 0, "R10 setup");
    nops(2);
    dir(RDA, 1, 0, 0, "R10 read auto");
    nops(5);
    dir(ACT, 1, 0, 0, "R10 read auto boundary");

    doReset();
    dir(MRS, 0, 0, 0, "R11 mode set");
    dir(ACT, 2, 0, 2, "R11 early activate");
    doReset();
    dir(MRS, 0, 0, 0, "R11 mode set");
    nops(1);
    dir(ACT, 2, 0, 0, "R11 boundary");

    doReset();
    dir(SRX, 0, 0, 0, "R12 exit");
    dir(ACT, 0, 0, 1, "R12 command in window");
    doReset();
    dir(SRX, 0, 0, 0, "R12 exit");
    dir(NOP, 0, 0, 0, "R12 NOP in window");
    dir(ACT, 0, 0, 0, "R12 boundary");

    doReset();
    dir(ACT, 0, 0, 0, "R13 setup");
    dir(MRS, 0, 0, 0, "R13 mode");
    dir(SRX, 0, 0, 0, "R13 exit");
    dir(ACT, 0, 0, 1, "R13 priority exit over row cycle");
    doReset();
    dir(ACT, 2, 0, 0, "R13 setup");
    nops(1);
    dir(RD, 2, 0, 0, "R13 read");
    dir(PRE, 2, 0, 8, "R13 priority row open over read");

    for (int pass = 0; pass < 2; pass++) begin
      doReset();
      for (int i = 0; i < 1500; i++) begin
        r = $urandom_range(0, 15);
        if (r < 6) c = NOP;
        else if (r < 8) c = ACT;
        else if (r == 8) c = RD;
        else if (r == 9) c = RDA;
        else if (r == 10) c = WR;
        else if (r == 11) c = WRA;
        else if (r < 14) c = PRE;
        else if (r == 14) c = ($urandom_range(0, 3) == 0) ? MRS : DESL;
        else c = SRE + $urandom_range(0, 2);
        step(c, $urandom_range(0, 3), 1'($urandom_range(0, 1)), m);
        chk("R13 random against model", m, bank);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule